// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which of a UART's interrupt conditions the host should service first and presents that choice as an 8-bit identification byte on a read port. It also drives an active-high interrupt request line. The condition flags come from elsewhere in the UART: receiver line status, received data available, character timeout, transmitter holding register empty and modem status. Each flag is taken as already qualified by its enable bit. A FIFO-enable control bit and a host read strobe for the identification register complete the inputs.

The identification byte is registered and follows the live priority result one clock later. While the host read strobe is high, the byte is held, so one access sees one consistent cause. The transmitter-empty condition is special. Its pending state is held inside the block, set by a rising edge of its flag, and cleared when a read that reported it as the cause finishes.

Top module: `uart_irq_ident`

## Requirements
- R1: Sources are served in strict priority: line status (highest), then received data or character timeout (one shared level, with received data chosen when both are set), then transmitter empty, then modem status (lowest).
- R2: Bit 0 of the identification byte is 0 when any condition is pending and 1 when none is.
- R3: Bits 3..1 hold the cause code: 011 line status, 010 received data, 110 character timeout, 001 transmitter empty, 000 modem status. They read 000 when nothing is pending.
- R4: When FIFO mode is off, the character timeout flag is ignored. It does not affect the byte or the request line, and bit 3 reads 0.
- R5: Bits 5 and 4 always read 0.
- R6: Bits 7 and 6 both read 1 when FIFO mode is on and both read 0 when it is off.
- R7: While the read strobe is high, the identification byte does not change. Conditions that arrive during the read are still recorded, and the byte shows the current result one clock after the strobe falls. When the strobe is low, the byte reflects input changes one clock later.
- R8: A rising edge of the transmitter-empty flag makes that source pending one clock later. The pending state is cleared on the clock where a read ends, if the byte held during that read reported transmitter empty (code 001 with bit 0 low). A flag that stays high does not make the source pending again.
- R9: The request output is a register that holds the OR of all pending conditions, and it is never frozen by a read.
- R10: After reset the identification byte is 0x01, the request output is 0, and no transmitter-empty condition is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stat_flag | input | 1 | Receiver line status condition |
| rx_data_flag | input | 1 | Received data available condition |
| char_tmo_flag | input | 1 | Character timeout condition (used only in FIFO mode) |
| tx_empty_flag | input | 1 | Transmitter holding register empty level |
| modem_flag | input | 1 | Modem status condition |
| fifo_on | input | 1 | FIFO mode enable |
| ident_rd | input | 1 | Host read strobe, high for the whole access |
| ident_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
A bad transmitter-empty pending state has two visible symptoms. Either the request line stays high after the read that reported that cause, or code 001 reappears two clocks after the strobe falls. The bench reads twice and watches for both. A broken freeze register lets a higher cause appear while the strobe is still high, and this shows on the first sample taken after the new flag rises. An encoding or priority fault shows one clock after the flags change. Each source is therefore set alone and then together with the sources above and below it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W   = 8;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_MODEM   = 3'b000,
    CAUSE_TXEMPTY = 3'b001,
    CAUSE_RXDATA  = 3'b010,
    CAUSE_LINE    = 3'b011,
    CAUSE_TMO     = 3'b110
  } cause_e;

  typedef struct packed {
    logic   pending;
    cause_e cause;
  } irq_sel_t;

  localparam logic [ID_W-1:0] IDENT_IDLE = 8'h01;

  function automatic logic [ID_W-1:0] pack_ident(irq_sel_t s, logic fifo_mode);
    logic [ID_W-1:0] b;
    b      = '0;
    b[0]   = ~s.pending;
    b[3:1] = s.pending ? s.cause : CAUSE_MODEM;
    b[5:4] = 2'b00;
    b[7:6] = {2{fifo_mode}};
    return b;
  endfunction
endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic     line_stat,
  input  logic     rx_data,
  input  logic     char_tmo,
  input  logic     tx_empty,
  input  logic     modem,
  input  logic     fifo_mode,
  output irq_sel_t sel,
  output logic     any_pend
);
  logic tmo_ok;

  always_comb begin
    tmo_ok = char_tmo & fifo_mode;
    sel    = '{pending: 1'b0, cause: CAUSE_MODEM};
    if (line_stat) begin
      sel = '{pending: 1'b1, cause: CAUSE_LINE};
    end else if (rx_data) begin
      sel = '{pending: 1'b1, cause: CAUSE_RXDATA};
    end else if (tmo_ok) begin
      sel = '{pending: 1'b1, cause: CAUSE_TMO};
    end else if (tx_empty) begin
      sel = '{pending: 1'b1, cause: CAUSE_TXEMPTY};
    end else if (modem) begin
      sel = '{pending: 1'b1, cause: CAUSE_MODEM};
    end
    any_pend = line_stat | rx_data | tmo_ok | tx_empty | modem;
  end

  always_comb begin
    AST_PEND_MATCH: assert (sel.pending == any_pend); // R2
  end
endmodule

// File: rtl/uart_irq_txe_latch.sv
module uart_irq_txe_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty_lvl,
  input  logic clr_req,
  output logic pend
);
  logic lvl_q, lvl_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise  = tx_empty_lvl & ~lvl_q;
    lvl_d = tx_empty_lvl;
    if (rise) begin
      pend_d = 1'b1;
    end else if (clr_req) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_TXE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pend_q); // R8
  AST_TXE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !rise) |=> !pend_q); // R8
  AST_TXE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !clr_req) |=> $stable(pend_q)); // R8
endmodule

// File: rtl/uart_irq_freeze.sv
module uart_irq_freeze
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_strobe,
  input  logic [ID_W-1:0] live_ident,
  output logic [ID_W-1:0] shown_ident,
  output logic            rd_end,
  output logic            shown_txe
);
  logic [ID_W-1:0] id_q, id_d;
  logic            rd_q, rd_d;
  logic            id_en;

  always_comb begin
    id_en  = ~rd_strobe;
    id_d   = id_en ? live_ident : id_q;
    rd_d   = rd_strobe;
    rd_end = rd_q & ~rd_strobe;
    shown_txe = ~id_q[0] & (id_q[3:1] == CAUSE_TXEMPTY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= IDENT_IDLE;
      rd_q <= 1'b0;
    end else begin
      id_q <= id_d;
      rd_q <= rd_d;
    end
  end

  assign shown_ident = id_q;

  AST_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> $stable(id_q)); // R7
  AST_FOLLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> (id_q == $past(live_ident))); // R7
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stat_flag,
  input  logic       rx_data_flag,
  input  logic       char_tmo_flag,
  input  logic       tx_empty_flag,
  input  logic       modem_flag,
  input  logic       fifo_on,
  input  logic       ident_rd,
  output logic [7:0] ident_byte,
  output logic       irq
);
  irq_sel_t        sel;
  logic            any_pend;
  logic            txe_pend;
  logic            txe_clr;
  logic            rd_end;
  logic            shown_txe;
  logic [ID_W-1:0] live_ident;
  logic [ID_W-1:0] shown_ident;
  logic            irq_q, irq_d;

  uart_irq_txe_latch u_txe (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_empty_lvl (tx_empty_flag),
    .clr_req      (txe_clr),
    .pend         (txe_pend)
  );

  uart_irq_prio u_prio (
    .line_stat (line_stat_flag),
    .rx_data   (rx_data_flag),
    .char_tmo  (char_tmo_flag),
    .tx_empty  (txe_pend),
    .modem     (modem_flag),
    .fifo_mode (fifo_on),
    .sel       (sel),
    .any_pend  (any_pend)
  );

  uart_irq_freeze u_frz (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (ident_rd),
    .live_ident  (live_ident),
    .shown_ident (shown_ident),
    .rd_end      (rd_end),
    .shown_txe   (shown_txe)
  );

  always_comb begin
    live_ident = pack_ident(sel, fifo_on);
    txe_clr    = rd_end & shown_txe;
    irq_d      = any_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign ident_byte = shown_ident;
  assign irq        = irq_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ident_byte[5:4] == 2'b00); // R5
  AST_FIFO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ident_byte[7] == ident_byte[6]); // R6
  AST_NO_TMO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ident_byte[7] |-> !ident_byte[3]); // R4
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    line_stat_flag |=> irq); // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ident_byte[0] |-> (ident_byte[3:1] == 3'b000)); // R3
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  logic       clk;
  logic       rst_n;
  logic       line_stat_flag, rx_data_flag, char_tmo_flag;
  logic       tx_empty_flag, modem_flag, fifo_on, ident_rd;
  logic [7:0] ident_byte;
  logic       irq;

  int n_checks;
  int n_fail;
  bit done;

  uart_irq_ident dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_stat_flag (line_stat_flag),
    .rx_data_flag   (rx_data_flag),
    .char_tmo_flag  (char_tmo_flag),
    .tx_empty_flag  (tx_empty_flag),
    .modem_flag     (modem_flag),
    .fifo_on        (fifo_on),
    .ident_rd       (ident_rd),
    .ident_byte     (ident_byte),
    .irq            (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flags();
    line_stat_flag = 0; rx_data_flag = 0; char_tmo_flag = 0;
    tx_empty_flag = 0; modem_flag = 0; ident_rd = 0;
  endtask

  task automatic t_reset();
    clear_flags();
    fifo_on = 0;
    rst_n = 0;
    wait_cyc(3);
    check("R10 ident after reset", ident_byte, 8'h01);
    check("R10 irq after reset", {7'd0, irq}, 8'h00);
    rst_n = 1;
    wait_cyc(2);
    check("R10 idle after release", ident_byte, 8'h01);
  endtask

  task automatic t_priority();
    fifo_on = 0;
    modem_flag = 1; wait_cyc(1);
    check("R9 irq one clock after modem", {7'd0, irq}, 8'h01);
    check("R3 modem code", ident_byte, 8'h00);
    rx_data_flag = 1; wait_cyc(1);
    check("R1 rx data over modem", ident_byte, 8'h04);
    line_stat_flag = 1; wait_cyc(1);
    check("R1 line over rx data", ident_byte, 8'h06);
    line_stat_flag = 0; wait_cyc(1);
    check("R1 rx data after line drops", ident_byte, 8'h04);
    clear_flags(); wait_cyc(1);
    check("R2 idle bit0 high", ident_byte, 8'h01);
    check("R9 irq low when idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_fifo();
    fifo_on = 0;
    char_tmo_flag = 1; wait_cyc(2);
    check("R4 timeout ignored off FIFO", ident_byte, 8'h01);
    check("R4 no irq from timeout off FIFO", {7'd0, irq}, 8'h00);
    fifo_on = 1; wait_cyc(2);
    check("R3 timeout code in FIFO mode", ident_byte, 8'hCC);
    check("R9 irq from timeout", {7'd0, irq}, 8'h01);
    rx_data_flag = 1; wait_cyc(1);
    check("R1 rx data over timeout", ident_byte, 8'hC4);
    clear_flags(); wait_cyc(1);
    check("R6 FIFO bits on idle", ident_byte, 8'hC1);
    fifo_on = 0; wait_cyc(1);
    check("R6 FIFO bits off", ident_byte, 8'h01);
  endtask

  task automatic t_freeze();
    fifo_on = 0;
    rx_data_flag = 1; wait_cyc(2);
    ident_rd = 1; wait_cyc(1);
    line_stat_flag = 1; wait_cyc(2);
    check("R7 frozen during read", ident_byte, 8'h04);
    check("R9 irq not frozen", {7'd0, irq}, 8'h01);
    ident_rd = 0; wait_cyc(1);
    check("R7 new cause after read", ident_byte, 8'h06);
    clear_flags(); wait_cyc(2);
  endtask

  task automatic t_txe_clear();
    fifo_on = 0;
    tx_empty_flag = 1; wait_cyc(1);
    check("R8 not yet pending", ident_byte, 8'h01);
    wait_cyc(1);
    check("R8 tx empty code", ident_byte, 8'h02);
    check("R8 irq from tx empty", {7'd0, irq}, 8'h01);
    ident_rd = 1; wait_cyc(2);
    ident_rd = 0; wait_cyc(3);
    check("R8 cleared by read", ident_byte, 8'h01);
    check("R8 irq low after clear", {7'd0, irq}, 8'h00);
    tx_empty_flag = 0; wait_cyc(1);
    tx_empty_flag = 1; wait_cyc(2);
    check("R8 new edge sets again", ident_byte, 8'h02);
    rx_data_flag = 1; wait_cyc(1);
    ident_rd = 1; wait_cyc(2);
    ident_rd = 0; wait_cyc(1);
    rx_data_flag = 0; wait_cyc(2);
    check("R8 kept when another cause was read", ident_byte, 8'h02);
    ident_rd = 1; wait_cyc(1);
    ident_rd = 0; wait_cyc(2);
    check("R8 cleared on its own read", ident_byte, 8'h01);
    clear_flags(); wait_cyc(2);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    t_reset();
    t_priority();
    t_fifo();
    t_freeze();
    t_txe_clear();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule